// File: doc/BRIEF.md
# Frame Buffer Address Generator

This block produces the fetch addresses that a display controller needs to read a frame buffer one visible line at a time. The viewport is a window into a larger virtual screen. Each line reads a run of half-words, then jumps forward over a gap to reach the start of the next line. That gap is what lets software scroll the view horizontally without moving any pixel data. All addresses are kept in half-word units. A 7-bit bank field supplies the upper address bits, and the walker never changes it.

A timing generator starts each frame with a `frame_start` strobe and opens each line with a `line_go` strobe. The walker then offers 32-bit word fetches on a valid/ready request stream, two half-words per request. It pulses `eof` once the last line is finished. In parallel, the block works out the frame's end position from the live geometry inputs and flags a frame that would run past the bank. Words returning from memory pass through a lane stage. That stage can swap bytes, swap half-words, and add a palette offset to 8-bit pixel indices. It is a pure combinational path with ready passed straight back to the source.

Back-pressure rules:
- Request stream: while `req_valid` is high and `req_ready` is low, the address is held.
- Data stream: `rd_ready` follows `px_ready` in the same cycle, and `px_valid` follows `rd_valid`.

Top module: `fbaddr_gen`

## Requirements
- R1: While reset is held and right after it, the block presents a fixed idle state: `req_valid`, `eof` and `bank_err` are 0, and `end_addr` is 0.
- R2: A request's byte address is laid out as follows. Bits 31:29 are 0. Bits 28:22 carry the bank latched at frame start. Bits 21:1 carry the half-word address. Bit 0 is 0.
- R3: `frame_start` does two things. It loads the line start with `cfg_base`, and it latches the bank, page width, offset size and last-line index for the whole frame. Changing the configuration inputs later has no effect on the addresses of that frame. A `frame_start` in the middle of a frame abandons it and restarts at the new base.
- R4: Requests are offered only between a `line_go` and the end of that line, and only while a frame is armed. A `line_go` that arrives while a line is still open is ignored.
- R5: Within a line, successive requests advance by 2 half-words (4 bytes). A line issues ceil(page_width/2) requests. A page width of 0 completes the line on `line_go` without issuing any request.
- R6: The first address of each following line equals the previous line's first address plus page width plus offset size, in half-words.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_addr` stays unchanged.
- R8: `eof` is a single-cycle pulse. It appears in the cycle after the handshake of the last request of line index `cfg_last_line`. After it, no request is offered until the next `frame_start`.
- R9: `end_addr` equals the low 21 bits of base + (page_width + offset_size) * (last_line + 1). It is computed from the live inputs with one cycle of latency. `bank_err` is 1 when that sum does not fit in 21 bits.
- R10: `byte_swap`=1 exchanges the two bytes inside each 16-bit half of the word. `half_swap`=1 exchanges the two 16-bit halves. With both set, the four bytes come out in reverse order.
- R11: When `pix_fmt` is 4'b1011 (8 bits per pixel) and `pal_en` is 1, `pal_off` is added modulo 256 to every byte lane after swapping. With `pix_fmt` 4'b1100 (16 bits per pixel), or with `pal_en` at 0, the data is not modified.
- R12: The data path holds no storage. `px_valid` equals `rd_valid` and `rd_ready` equals `px_ready` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_bank | input | 7 | Fixed upper address field (byte address bits 28:22) |
| cfg_base | input | 21 | Frame start position, in half-words |
| cfg_page_width | input | 11 | Half-words fetched per line |
| cfg_off_size | input | 11 | Half-words skipped after each line |
| cfg_last_line | input | 10 | Index of the last line (line count minus one) |
| frame_start | input | 1 | Strobe: reload and arm a new frame |
| line_go | input | 1 | Strobe: open the next line |
| req_valid | output | 1 | Request stream valid |
| req_ready | input | 1 | Request stream ready |
| req_addr | output | 32 | Byte address of the 32-bit word fetch |
| eof | output | 1 | One-cycle pulse when the frame is done |
| end_addr | output | 21 | Computed end position, in half-words |
| bank_err | output | 1 | End position overflows the bank |
| byte_swap | input | 1 | Swap bytes within each half-word |
| half_swap | input | 1 | Swap the two half-words |
| pix_fmt | input | 4 | Pixel format code (4'b1011 = 8 bpp, 4'b1100 = 16 bpp) |
| pal_en | input | 1 | Enable the palette index offset |
| pal_off | input | 8 | Palette index offset |
| rd_valid | input | 1 | Returned data valid |
| rd_ready | output | 1 | Returned data ready |
| rd_data | input | 32 | Returned 32-bit word |
| px_valid | output | 1 | Processed data valid |
| px_ready | input | 1 | Processed data ready |
| px_data | output | 32 | Processed 32-bit word |

## Verification
Several properties are checked on every cycle by assertions:
- a stalled request holds its address;
- an unstalled request inside a line moves up by exactly one word;
- `eof` is a lone pulse during which no request is offered;
- a non-overflowing end position never falls below the base;
- the swap stage, with the palette inactive, keeps the number of set bits.

Other behaviours can only be shown by the bench's scenarios. These cover:
- the exact address sequences across lines;
- the jump over the offset gap;
- configuration latched at frame start;
- a mid-frame restart;
- lines of zero width;
- the exact end value and the bank boundary;
- the specific byte orders and palette sums.

// File: rtl/fbag_pkg.sv
package fbag_pkg;
  localparam int BANK_W_DEF = 7;
  localparam int HW_W_DEF   = 21;
  localparam int SPAN_W_DEF = 11;
  localparam int LINE_W_DEF = 10;
  localparam int ADDR_W_DEF = 32;
  localparam int WORD_W_DEF = 32;

  // pixel format codes decoded by the lane stage
  localparam logic [3:0] PIX_8BPP  = 4'b1011;
  localparam logic [3:0] PIX_16BPP = 4'b1100;

  // half-words covered by one word request
  localparam int HW_PER_REQ = 2;
endpackage

// File: rtl/fbag_walker.sv
module fbag_walker
  import fbag_pkg::*;
#(
  parameter int BANK_W = BANK_W_DEF,
  parameter int HW_W   = HW_W_DEF,
  parameter int SPAN_W = SPAN_W_DEF,
  parameter int LINE_W = LINE_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_go,
  input  logic [BANK_W-1:0] bank,
  input  logic [HW_W-1:0]   base,
  input  logic [SPAN_W-1:0] page_width,
  input  logic [SPAN_W-1:0] off_size,
  input  logic [LINE_W-1:0] last_line,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic              eof
);
  localparam int USED_W = BANK_W + HW_W + 1;
  localparam int PAD_W  = ADDR_W - USED_W;

  logic              armed;
  logic              line_open;
  logic [LINE_W-1:0] line_idx;
  logic [SPAN_W-1:0] pos;
  logic [HW_W-1:0]   line_base;
  logic [BANK_W-1:0] bank_q;
  logic [SPAN_W-1:0] pw_q;
  logic [SPAN_W-1:0] off_q;
  logic [LINE_W-1:0] last_q;
  logic              eof_q;

  logic [SPAN_W:0]   pos_plus;
  logic              line_end;
  logic              fire;
  logic              empty_line;
  logic              advance;
  logic [HW_W-1:0]   hw_addr;

  assign pos_plus   = {1'b0, pos} + (SPAN_W+1)'(HW_PER_REQ);
  assign line_end   = pos_plus >= {1'b0, pw_q};
  assign req_valid  = armed && line_open;
  assign fire       = req_valid && req_ready;
  assign empty_line = armed && !line_open && line_go && (pw_q == '0);
  assign advance    = (fire && line_end) || empty_line;
  assign hw_addr    = line_base + HW_W'(pos);
  assign eof        = eof_q;

  generate
    if (PAD_W > 0) begin : g_pad
      assign req_addr = {{PAD_W{1'b0}}, bank_q, hw_addr, 1'b0};
    end else begin : g_nopad
      assign req_addr = {bank_q, hw_addr, 1'b0};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      line_open <= 1'b0;
      line_idx  <= '0;
      pos       <= '0;
      line_base <= '0;
      bank_q    <= '0;
      pw_q      <= '0;
      off_q     <= '0;
      last_q    <= '0;
      eof_q     <= 1'b0;
    end else begin
      eof_q <= 1'b0;
      if (frame_start) begin
        armed     <= 1'b1;
        line_open <= 1'b0;
        line_idx  <= '0;
        pos       <= '0;
        line_base <= base;
        bank_q    <= bank;
        pw_q      <= page_width;
        off_q     <= off_size;
        last_q    <= last_line;
      end else begin
        if (armed && !line_open && line_go && (pw_q != '0))
          line_open <= 1'b1;
        if (fire && !line_end)
          pos <= pos_plus[SPAN_W-1:0];
        if (advance) begin
          line_open <= 1'b0;
          pos       <= '0;
          line_base <= line_base + HW_W'(pw_q) + HW_W'(off_q);
          if (line_idx == last_q) begin
            armed <= 1'b0;
            eof_q <= 1'b1;
          end else begin
            line_idx <= line_idx + 1'b1;
          end
        end
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !frame_start) |=> (req_valid && $stable(req_addr))); // R7

  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !line_end && !frame_start) |=> (req_valid && req_addr == $past(req_addr) + ADDR_W'(4))); // R5

  AST_EOF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> !req_valid); // R8

  AST_EOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> !eof); // R8
endmodule

// File: rtl/fbag_endcalc.sv
module fbag_endcalc
  import fbag_pkg::*;
#(
  parameter int HW_W   = HW_W_DEF,
  parameter int SPAN_W = SPAN_W_DEF,
  parameter int LINE_W = LINE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HW_W-1:0]   base,
  input  logic [SPAN_W-1:0] page_width,
  input  logic [SPAN_W-1:0] off_size,
  input  logic [LINE_W-1:0] last_line,
  output logic [HW_W-1:0]   end_addr,
  output logic              bank_err
);
  localparam int SUM_W  = SPAN_W + 1;
  localparam int CNT_W  = LINE_W + 1;
  localparam int PROD_W = SUM_W + CNT_W;
  localparam int FULL_W = ((PROD_W > HW_W) ? PROD_W : HW_W) + 1;

  logic [SUM_W-1:0]  stride;
  logic [CNT_W-1:0]  n_lines;
  logic [PROD_W-1:0] span_total;
  logic [FULL_W-1:0] full_end;
  logic              over;

  assign stride     = {1'b0, page_width} + {1'b0, off_size};
  assign n_lines    = {1'b0, last_line} + CNT_W'(1);
  assign span_total = PROD_W'(stride) * PROD_W'(n_lines);
  assign full_end   = FULL_W'(base) + FULL_W'(span_total);
  assign over       = |full_end[FULL_W-1:HW_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      end_addr <= '0;
      bank_err <= 1'b0;
    end else begin
      end_addr <= full_end[HW_W-1:0];
      bank_err <= over;
    end
  end

  AST_END_ABOVE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_err && $past(rst_n)) |-> (end_addr >= $past(base))); // R9
endmodule

// File: rtl/fbag_lanes.sv
module fbag_lanes
  import fbag_pkg::*;
#(
  parameter int WORD_W = WORD_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_swap,
  input  logic              half_swap,
  input  logic [3:0]        pix_fmt,
  input  logic              pal_en,
  input  logic [7:0]        pal_off,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  localparam int HALVES = WORD_W / 16;
  localparam int LANES  = WORD_W / 8;

  logic [WORD_W-1:0] bsw;
  logic [WORD_W-1:0] hsw;
  logic              pal_act;

  assign pal_act   = pal_en && (pix_fmt == PIX_8BPP);
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  generate
    for (genvar h = 0; h < HALVES; h++) begin : g_half
      assign bsw[h*16 +: 8]   = byte_swap ? in_data[h*16+8 +: 8] : in_data[h*16 +: 8];
      assign bsw[h*16+8 +: 8] = byte_swap ? in_data[h*16 +: 8]   : in_data[h*16+8 +: 8];
      assign hsw[h*16 +: 16]  = half_swap ? bsw[(h^1)*16 +: 16]  : bsw[h*16 +: 16];
    end
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign out_data[l*8 +: 8] = hsw[l*8 +: 8] + (pal_act ? pal_off : 8'd0);
    end
  endgenerate

  AST_SWAP_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pal_act) |-> ($countones(out_data) == $countones(in_data))); // R10
endmodule

// File: rtl/fbaddr_gen.sv
module fbaddr_gen
  import fbag_pkg::*;
#(
  parameter int BANK_W = BANK_W_DEF,
  parameter int HW_W   = HW_W_DEF,
  parameter int SPAN_W = SPAN_W_DEF,
  parameter int LINE_W = LINE_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int WORD_W = WORD_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [HW_W-1:0]   cfg_base,
  input  logic [SPAN_W-1:0] cfg_page_width,
  input  logic [SPAN_W-1:0] cfg_off_size,
  input  logic [LINE_W-1:0] cfg_last_line,
  input  logic              frame_start,
  input  logic              line_go,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic              eof,
  output logic [HW_W-1:0]   end_addr,
  output logic              bank_err,
  input  logic              byte_swap,
  input  logic              half_swap,
  input  logic [3:0]        pix_fmt,
  input  logic              pal_en,
  input  logic [7:0]        pal_off,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [WORD_W-1:0] rd_data,
  output logic              px_valid,
  input  logic              px_ready,
  output logic [WORD_W-1:0] px_data
);
  fbag_walker #(
    .BANK_W(BANK_W), .HW_W(HW_W), .SPAN_W(SPAN_W), .LINE_W(LINE_W), .ADDR_W(ADDR_W)
  ) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .line_go    (line_go),
    .bank       (cfg_bank),
    .base       (cfg_base),
    .page_width (cfg_page_width),
    .off_size   (cfg_off_size),
    .last_line  (cfg_last_line),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .eof        (eof)
  );

  fbag_endcalc #(
    .HW_W(HW_W), .SPAN_W(SPAN_W), .LINE_W(LINE_W)
  ) u_endcalc (
    .clk       (clk),
    .rst_n     (rst_n),
    .base      (cfg_base),
    .page_width(cfg_page_width),
    .off_size  (cfg_off_size),
    .last_line (cfg_last_line),
    .end_addr  (end_addr),
    .bank_err  (bank_err)
  );

  fbag_lanes #(
    .WORD_W(WORD_W)
  ) u_lanes (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_swap(byte_swap),
    .half_swap(half_swap),
    .pix_fmt  (pix_fmt),
    .pal_en   (pal_en),
    .pal_off  (pal_off),
    .in_valid (rd_valid),
    .in_ready (rd_ready),
    .in_data  (rd_data),
    .out_valid(px_valid),
    .out_ready(px_ready),
    .out_data (px_data)
  );
endmodule

// File: tb/fbaddr_gen_test.sv
module fbaddr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  cfg_bank;
  logic [20:0] cfg_base;
  logic [10:0] cfg_page_width;
  logic [10:0] cfg_off_size;
  logic [9:0]  cfg_last_line;
  logic        frame_start, line_go;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic        eof;
  logic [20:0] end_addr;
  logic        bank_err;
  logic        byte_swap, half_swap;
  logic [3:0]  pix_fmt;
  logic        pal_en;
  logic [7:0]  pal_off;
  logic        rd_valid, rd_ready;
  logic [31:0] rd_data;
  logic        px_valid, px_ready;
  logic [31:0] px_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fbaddr_gen uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(input logic [6:0] b, input logic [20:0] hw);
    return {3'b000, b, hw, 1'b0};
  endfunction

  task automatic start_frame(input logic [6:0] b, input logic [20:0] base,
                             input logic [10:0] pw, input logic [10:0] off, input logic [9:0] last);
    @(negedge clk);
    cfg_bank = b; cfg_base = base; cfg_page_width = pw; cfg_off_size = off; cfg_last_line = last;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic pulse_line;
    line_go = 1'b1;
    @(negedge clk);
    line_go = 1'b0;
  endtask

  // runs one line with ready high; enters and leaves at a negedge
  task automatic run_line(input logic [6:0] b, input logic [20:0] lb, input int pw,
                          input bit last, input string tag);
    int words = (pw + 1) / 2;
    req_ready = 1'b1;
    pulse_line();
    for (int k = 0; k < words; k++) begin
      chk(req_valid === 1'b1, {tag, " valid"}, 32'(req_valid), 32'd1);
      chk(req_addr === mk_addr(b, lb + 21'(2*k)), {tag, " addr"}, req_addr, mk_addr(b, lb + 21'(2*k)));
      @(negedge clk);
    end
    chk(req_valid === 1'b0, {tag, " line closed R4"}, 32'(req_valid), 32'd0);
    chk(eof === last, {tag, " eof R8"}, 32'(eof), 32'(last));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_valid === 1'b0, "R1 req_valid", 32'(req_valid), 0);
    chk(eof === 1'b0, "R1 eof", 32'(eof), 0);
    chk(bank_err === 1'b0, "R1 bank_err", 32'(bank_err), 0);
    chk(end_addr === 21'd0, "R1 end_addr", 32'(end_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_valid === 1'b0, "R1 idle after reset", 32'(req_valid), 0);
  endtask

  task automatic t_basic;
    start_frame(7'h05, 21'h100, 11'd8, 11'd4, 10'd2);
    repeat (3) begin
      chk(req_valid === 1'b0, "R4 no request before line_go", 32'(req_valid), 0);
      @(negedge clk);
    end
    run_line(7'h05, 21'h100, 8, 0, "R5 R2 line0");
    run_line(7'h05, 21'h10C, 8, 0, "R6 line1");
    run_line(7'h05, 21'h118, 8, 1, "R6 line2");
    @(negedge clk);
    chk(eof === 1'b0, "R8 eof single pulse", 32'(eof), 0);
    pulse_line();
    chk(req_valid === 1'b0, "R8 quiet after frame", 32'(req_valid), 0);
    chk(end_addr === 21'h124, "R9 end value", 32'(end_addr), 32'h124);
    chk(bank_err === 1'b0, "R9 no overflow", 32'(bank_err), 0);
  endtask

  task automatic t_odd;
    start_frame(7'h7F, 21'h001, 11'd5, 11'd3, 10'd1);
    run_line(7'h7F, 21'h001, 5, 0, "R5 odd width line0");
    run_line(7'h7F, 21'h009, 5, 1, "R6 R2 odd width line1");
  endtask

  task automatic t_backpressure;
    logic [31:0] held;
    start_frame(7'h01, 21'h040, 11'd4, 11'd0, 10'd0);
    req_ready = 1'b0;
    pulse_line();
    held = req_addr;
    chk(held === mk_addr(7'h01, 21'h040), "R7 first addr", held, mk_addr(7'h01, 21'h040));
    repeat (3) begin
      @(negedge clk);
      chk(req_valid === 1'b1 && req_addr === held, "R7 held under stall", req_addr, held);
    end
    req_ready = 1'b1;
    @(negedge clk);
    chk(req_addr === mk_addr(7'h01, 21'h042), "R7 after release", req_addr, mk_addr(7'h01, 21'h042));
    @(negedge clk);
    chk(eof === 1'b1 && req_valid === 1'b0, "R8 eof after single line", 32'(eof), 1);
  endtask

  task automatic t_latch;
    start_frame(7'h02, 21'h200, 11'd4, 11'd2, 10'd1);
    cfg_bank = 7'h03; cfg_base = 21'h500; cfg_page_width = 11'd10; cfg_off_size = 11'd9; cfg_last_line = 10'd7;
    // open line 0 under stall, then a second line_go that must be ignored
    req_ready = 1'b0;
    pulse_line();
    pulse_line();
    req_ready = 1'b1;
    chk(req_addr === mk_addr(7'h02, 21'h200), "R3 latched bank and base", req_addr, mk_addr(7'h02, 21'h200));
    @(negedge clk);
    chk(req_addr === mk_addr(7'h02, 21'h202), "R3 latched step", req_addr, mk_addr(7'h02, 21'h202));
    @(negedge clk);
    chk(req_valid === 1'b0, "R4 ignored line_go opened nothing", 32'(req_valid), 0);
    run_line(7'h02, 21'h206, 4, 1, "R3 latched geometry line1");
  endtask

  task automatic t_restart;
    start_frame(7'h04, 21'h300, 11'd6, 11'd0, 10'd3);
    req_ready = 1'b1;
    pulse_line();
    @(negedge clk);
    chk(req_addr === mk_addr(7'h04, 21'h302), "R3 partial line", req_addr, mk_addr(7'h04, 21'h302));
    req_ready = 1'b0;
    start_frame(7'h06, 21'h050, 11'd2, 11'd2, 10'd0);
    chk(req_valid === 1'b0, "R3 restart drops open line", 32'(req_valid), 0);
    run_line(7'h06, 21'h050, 2, 1, "R3 restart new base");
  endtask

  task automatic t_zero_width;
    start_frame(7'h00, 21'h010, 11'd0, 11'd6, 10'd1);
    pulse_line();
    chk(req_valid === 1'b0 && eof === 1'b0, "R5 zero width line0", 32'(req_valid), 0);
    pulse_line();
    chk(req_valid === 1'b0 && eof === 1'b1, "R5 zero width frame ends", 32'(eof), 1);
    chk(end_addr === 21'h01C, "R9 end with zero width", 32'(end_addr), 32'h01C);
  endtask

  task automatic t_bank_edge;
    @(negedge clk);
    cfg_base = 21'h1FFFE0; cfg_page_width = 11'd16; cfg_off_size = 11'd0; cfg_last_line = 10'd0;
    @(negedge clk);
    chk(end_addr === 21'h1FFFF0 && bank_err === 1'b0, "R9 just inside bank", 32'(end_addr), 32'h1FFFF0);
    cfg_base = 21'h1FFFF0;
    @(negedge clk);
    chk(bank_err === 1'b1, "R9 reaching bank limit flags", 32'(bank_err), 1);
    chk(end_addr === 21'h0, "R9 truncated end", 32'(end_addr), 0);
    cfg_base = 21'h0; cfg_page_width = 11'd2047; cfg_off_size = 11'd2047; cfg_last_line = 10'd1023;
    @(negedge clk);
    chk(bank_err === 1'b1, "R9 largest geometry flags", 32'(bank_err), 1);
    chk(end_addr === 21'(4094 * 1024), "R9 largest geometry value", 32'(end_addr), 32'(21'(4094 * 1024)));
  endtask

  task automatic t_swap;
    pix_fmt = 4'b1100; pal_en = 1'b0; rd_valid = 1'b1; px_ready = 1'b1;
    rd_data = 32'h11223344;
    byte_swap = 0; half_swap = 0; #1;
    chk(px_data === 32'h11223344, "R10 no swap", px_data, 32'h11223344);
    byte_swap = 1; half_swap = 0; #1;
    chk(px_data === 32'h22114433, "R10 byte swap", px_data, 32'h22114433);
    byte_swap = 0; half_swap = 1; #1;
    chk(px_data === 32'h33441122, "R10 half swap", px_data, 32'h33441122);
    byte_swap = 1; half_swap = 1; #1;
    chk(px_data === 32'h44332211, "R10 both swaps", px_data, 32'h44332211);
    byte_swap = 0; half_swap = 0;
  endtask

  task automatic t_palette;
    rd_data = 32'h01F0FF02; pal_off = 8'h10;
    pix_fmt = 4'b1011; pal_en = 1; #1;
    chk(px_data === 32'h11000F12, "R11 offset added per lane", px_data, 32'h11000F12);
    pal_en = 0; #1;
    chk(px_data === 32'h01F0FF02, "R11 disabled", px_data, 32'h01F0FF02);
    pix_fmt = 4'b1100; pal_en = 1; #1;
    chk(px_data === 32'h01F0FF02, "R11 16bpp unmodified", px_data, 32'h01F0FF02);
    pix_fmt = 4'b1011; half_swap = 1; #1;
    chk(px_data === 32'h0F121100, "R11 offset after swap", px_data, 32'h0F121100);
    half_swap = 0; pal_en = 0;
  endtask

  task automatic t_stream;
    rd_valid = 1; px_ready = 0; #1;
    chk(px_valid === 1'b1 && rd_ready === 1'b0, "R12 stall passes back", 32'(rd_ready), 0);
    rd_valid = 0; px_ready = 1; #1;
    chk(px_valid === 1'b0 && rd_ready === 1'b1, "R12 ready passes back", 32'(px_valid), 0);
    rd_valid = 1; #1;
    chk(px_valid === 1'b1, "R12 valid passes through", 32'(px_valid), 1);
  endtask

  initial begin
    rst_n = 0; cfg_bank = 0; cfg_base = 0; cfg_page_width = 0; cfg_off_size = 0; cfg_last_line = 0;
    frame_start = 0; line_go = 0; req_ready = 0;
    byte_swap = 0; half_swap = 0; pix_fmt = 0; pal_en = 0; pal_off = 0;
    rd_valid = 0; rd_data = 0; px_ready = 0;
    t_reset();
    t_basic();
    t_odd();
    t_backpressure();
    t_latch();
    t_restart();
    t_zero_width();
    t_bank_edge();
    @(negedge clk);
    t_swap();
    t_palette();
    t_stream();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule